// File: doc/BRIEF.md
# Prefetchable Burst Read Termination Controller

This block decides how a bus target ends a prefetchable burst read. The target hands read data out of a response buffer, and a back-end interconnect refills that buffer. The block watches the buffer-empty status, the request and return strobes of the interconnect, and the completed data phases on the bus. From these it chooses, each cycle, between letting the burst continue, inserting a wait state, disconnecting, or signalling a target abort.

A burst starts when a read is accepted while the buffer is available. The burst is then active until one of four terminations occurs. A target abort on a read has the highest priority. A single-phase termination follows, used when the burst would cross the address window or runs in cacheline wrap mode. Next comes an idle timeout while data is still in flight. The lowest priority is a plain completion when the buffer is empty and nothing is outstanding.

Every termination except the plain completion enters a drain phase. In the drain phase, returning words are thrown away and the buffer stays locked until the interconnect owes nothing more. A counter tracks the words still owed by the interconnect. A second counter measures the cycles since the last data phase and saturates at its limit.

Top module: `burst_rd_term`

## Requirements
- R1: After reset `buf_avail_o` is 1 and `wait_o`, `disconnect_o`, `abort_o` and `discard_o` are 0.
- R2: In an active burst, if `buf_empty_i` is 1 and no word is outstanding, `disconnect_o` is 1 in that cycle and `buf_avail_o` is 1 from the next cycle.
- R3: In an active burst, if `buf_empty_i` is 1, at least one word is outstanding, and fewer than IDLE_LIMIT (8) cycles have passed since the last data phase, `wait_o` is 1 and `disconnect_o` is 0.
- R4: When IDLE_LIMIT cycles have passed since the last data phase, with the buffer empty and words outstanding, `disconnect_o` is 1 for one cycle and the block enters the drain phase, where `buf_avail_o` is 0.
- R5: In the drain phase, each `data_ret_i` strobe gives `discard_o` = 1 in the same cycle. `buf_avail_o` stays 0 while any word is outstanding, and becomes 1 two cycles after the strobe that returns the last word.
- R6: With `boundary_i` = 1, the first `phase_done_i` of the burst gives `disconnect_o` = 1 in that cycle, and the block enters the drain phase. Before that phase, `disconnect_o` is 0.
- R7: With `wrap_i` = 1, the first `phase_done_i` gives `disconnect_o` = 1 in that cycle, and data still owed is discarded in the drain phase.
- R8: On a read (`txn_write_i` = 0), `abort_req_i` gives `abort_o` = 1 for one cycle. The block then drains, discarding in-flight returns, and releases the buffer only after the outstanding count reaches zero.
- R9: When `txn_write_i` = 1, `abort_req_i` has no effect: `abort_o` stays 0 and the burst continues to its normal termination.
- R10: An abort outranks a single-phase termination. In the abort cycle `disconnect_o` and `wait_o` are 0.
- R11: Each `phase_done_i` restarts the idle window, so the timeout disconnect comes only after IDLE_LIMIT further wait cycles.
- R12: While `buf_avail_o` is 0, `rd_start_i` is ignored. After release the block is idle: it gives no wait, no disconnect and no discard even when the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_start_i | input | 1 | New burst read presented; accepted only while the buffer is available |
| txn_write_i | input | 1 | Current transaction is a write |
| buf_empty_i | input | 1 | Response buffer holds no data |
| req_issue_i | input | 1 | One word requested from the interconnect |
| data_ret_i | input | 1 | One word returned by the interconnect |
| phase_done_i | input | 1 | A bus data phase completed this cycle |
| boundary_i | input | 1 | Burst would cross the address window boundary |
| wrap_i | input | 1 | Burst uses cacheline wrap ordering |
| abort_req_i | input | 1 | Request to end the transaction with a target abort |
| wait_o | output | 1 | Insert a wait state |
| disconnect_o | output | 1 | Issue a target disconnect |
| abort_o | output | 1 | Issue a target abort and flush the buffer |
| discard_o | output | 1 | Drop the word returned this cycle |
| buf_avail_o | output | 1 | Response buffer free for a new read |

## Verification
The bench counts the wait cycles before a timeout, both from a fresh data phase and after a phase in the middle of a stall. A timer that is off by one, or one that a phase does not restart, changes the count away from eight. It requests extra words after a disconnect and checks that each return is dropped. It also checks that the buffer stays locked until the last return and frees exactly two cycles later; a counter that ignores discarded words would release too early or never. It fires an abort together with a boundary phase, where a wrong priority would show a disconnect. It fires an abort on a write, which a design lacking the read-only gate would turn into a stray abort. Read starts during the drain must leave the block idle after release.

// File: rtl/burst_rd_term_pkg.sv
package burst_rd_term_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_DRAIN
  } term_state_e;

  typedef enum logic [2:0] {
    ACT_RUN,
    ACT_ABORT,
    ACT_SINGLE,
    ACT_TIMEOUT,
    ACT_EMPTY,
    ACT_STALL
  } term_act_e;

endpackage

// File: rtl/rd_inflight_ctr.sv
module rd_inflight_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rd_idle_timer.sv
module rd_idle_timer #(
  parameter int LIMIT = 8,
  parameter int W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         phase_i,
  output logic [W-1:0] cnt_o,
  output logic         expired_o
);

  localparam logic [W-1:0] LimVal = W'(LIMIT);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || phase_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LimVal) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == LimVal);

endmodule

// File: rtl/rd_term_arb.sv
module rd_term_arb
  import burst_rd_term_pkg::*;
(
  input  logic      active_i,
  input  logic      write_i,
  input  logic      abort_req_i,
  input  logic      single_i,
  input  logic      phase_i,
  input  logic      empty_i,
  input  logic      inflight_zero_i,
  input  logic      expired_i,
  output term_act_e act_o
);

  // fixed priority: abort, single phase, timeout, empty completion
  always_comb begin
    act_o = ACT_RUN;
    if (active_i) begin
      if (abort_req_i && !write_i) begin
        act_o = ACT_ABORT;
      end else if (single_i && phase_i) begin
        act_o = ACT_SINGLE;
      end else if (empty_i && !inflight_zero_i && expired_i) begin
        act_o = ACT_TIMEOUT;
      end else if (empty_i && inflight_zero_i) begin
        act_o = ACT_EMPTY;
      end else if (empty_i) begin
        act_o = ACT_STALL;
      end
    end
  end

endmodule

// File: rtl/burst_rd_term.sv
module burst_rd_term
  import burst_rd_term_pkg::*;
#(
  parameter int MAX_INFLIGHT = 16,
  parameter int IDLE_LIMIT   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_start_i,
  input  logic txn_write_i,
  input  logic buf_empty_i,
  input  logic req_issue_i,
  input  logic data_ret_i,
  input  logic phase_done_i,
  input  logic boundary_i,
  input  logic wrap_i,
  input  logic abort_req_i,
  output logic wait_o,
  output logic disconnect_o,
  output logic abort_o,
  output logic discard_o,
  output logic buf_avail_o
);

  localparam int CNT_W  = $clog2(MAX_INFLIGHT + 1);
  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);

  term_state_e      state_q, state_d;
  term_act_e        act;
  logic [CNT_W-1:0] inflight_q;
  logic [IDLE_W-1:0] idle_cnt;
  logic             inflight_zero;
  logic             idle_expired;
  logic             active;

  assign active = (state_q == ST_ACTIVE);

  rd_inflight_ctr #(
    .CNT_W (CNT_W)
  ) i_inflight (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (req_issue_i),
    .dec_i  (data_ret_i),
    .cnt_o  (inflight_q),
    .zero_o (inflight_zero)
  );

  rd_idle_timer #(
    .LIMIT (IDLE_LIMIT),
    .W     (IDLE_W)
  ) i_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (active),
    .phase_i   (phase_done_i),
    .cnt_o     (idle_cnt),
    .expired_o (idle_expired)
  );

  rd_term_arb i_arb (
    .active_i        (active),
    .write_i         (txn_write_i),
    .abort_req_i     (abort_req_i),
    .single_i        (boundary_i | wrap_i),
    .phase_i         (phase_done_i),
    .empty_i         (buf_empty_i),
    .inflight_zero_i (inflight_zero),
    .expired_i       (idle_expired),
    .act_o           (act)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (rd_start_i) state_d = ST_ACTIVE;
      ST_ACTIVE: begin
        unique case (act)
          ACT_ABORT, ACT_SINGLE, ACT_TIMEOUT: state_d = ST_DRAIN;
          ACT_EMPTY:                          state_d = ST_IDLE;
          default:                            state_d = ST_ACTIVE;
        endcase
      end
      ST_DRAIN:  if (inflight_zero) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign wait_o       = (act == ACT_STALL);
  assign abort_o      = (act == ACT_ABORT);
  assign disconnect_o = (act == ACT_SINGLE) || (act == ACT_TIMEOUT) || (act == ACT_EMPTY);
  assign discard_o    = (state_q == ST_DRAIN) && data_ret_i;
  assign buf_avail_o  = (state_q == ST_IDLE);

  logic unused_idle;
  assign unused_idle = ^idle_cnt;

endmodule

// File: rtl/burst_rd_term_chk.sv
module burst_rd_term_chk
  import burst_rd_term_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             txn_write_i,
  input logic             data_ret_i,
  input logic             wait_o,
  input logic             disconnect_o,
  input logic             abort_o,
  input logic             discard_o,
  input logic             buf_avail_o,
  input term_state_e      state_i,
  input logic [CNT_W-1:0] inflight_i
);

  a_r3_wait_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> !disconnect_o && !abort_o);

  a_r10_abort_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !disconnect_o && !wait_o);

  a_r9_no_wr_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_write_i |-> !abort_o);

  a_r5_discard_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> data_ret_i && !buf_avail_o);

  a_r5_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DRAIN && inflight_i != '0) |=> !buf_avail_o);

  a_r4_disc_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disconnect_o && inflight_i != '0) |=> !buf_avail_o);

  a_r2_release_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(buf_avail_o) |-> $past(inflight_i) == '0);

  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_avail_o |-> !wait_o && !disconnect_o && !discard_o);

endmodule

bind burst_rd_term burst_rd_term_chk #(
  .CNT_W (CNT_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .txn_write_i  (txn_write_i),
  .data_ret_i   (data_ret_i),
  .wait_o       (wait_o),
  .disconnect_o (disconnect_o),
  .abort_o      (abort_o),
  .discard_o    (discard_o),
  .buf_avail_o  (buf_avail_o),
  .state_i      (state_q),
  .inflight_i   (inflight_q)
);

// File: tb/test_burst_rd_term.sv
`timescale 1ns/1ps
module test_burst_rd_term;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic rd_start_i, txn_write_i, buf_empty_i, req_issue_i, data_ret_i;
  logic phase_done_i, boundary_i, wrap_i, abort_req_i;
  logic wait_o, disconnect_o, abort_o, discard_o, buf_avail_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_rd_term i_burst_rd_term (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_start_i   (rd_start_i),
    .txn_write_i  (txn_write_i),
    .buf_empty_i  (buf_empty_i),
    .req_issue_i  (req_issue_i),
    .data_ret_i   (data_ret_i),
    .phase_done_i (phase_done_i),
    .boundary_i   (boundary_i),
    .wrap_i       (wrap_i),
    .abort_req_i  (abort_req_i),
    .wait_o       (wait_o),
    .disconnect_o (disconnect_o),
    .abort_o      (abort_o),
    .discard_o    (discard_o),
    .buf_avail_o  (buf_avail_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr();
    rd_start_i = 0; txn_write_i = 0; buf_empty_i = 0; req_issue_i = 0;
    data_ret_i = 0; phase_done_i = 0; boundary_i = 0; wrap_i = 0; abort_req_i = 0;
  endtask

  // next cycle: inputs set at negedge, outputs looked at 1 ns later
  task automatic nxt();
    @(negedge clk_i);
    clr();
  endtask

  task automatic start_burst(input logic wr);
    nxt(); rd_start_i = 1; txn_write_i = wr; #1;
    chk("R12", "avail at start", buf_avail_o, 1);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "avail", buf_avail_o, 1);
    chk("R1", "wait", wait_o, 0);
    chk("R1", "disc", disconnect_o, 0);
    chk("R1", "abort", abort_o, 0);
    chk("R1", "discard", discard_o, 0);
  endtask

  task automatic t_normal();
    start_burst(0);
    nxt(); buf_empty_i = 1; #1;
    chk("R2", "disc empty", disconnect_o, 1);
    chk("R2", "no wait", wait_o, 0);
    nxt(); #1;
    chk("R2", "avail next", buf_avail_o, 1);
  endtask

  task automatic t_timeout();
    int n = 0;
    bit seen = 0;
    start_burst(0);
    nxt(); req_issue_i = 1; phase_done_i = 1; #1;
    for (int i = 0; i < 5; i++) begin
      nxt(); buf_empty_i = 1; #1;
      chk("R3", "wait in window", wait_o, 1);
      chk("R3", "no disc in window", disconnect_o, 0);
    end
    nxt(); phase_done_i = 1; #1;
    chk("R11", "no wait on phase", wait_o, 0);
    for (int i = 0; i < 12 && !seen; i++) begin
      nxt(); buf_empty_i = 1; #1;
      if (disconnect_o) seen = 1;
      else if (wait_o) n++;
    end
    chk("R4", "timeout disc", seen, 1);
    chk("R11", "waits after restart", n, 8);
    nxt(); req_issue_i = 1; #1;
    chk("R4", "drain after timeout", buf_avail_o, 0);
    nxt(); rd_start_i = 1; data_ret_i = 1; #1;
    chk("R5", "discard 1", discard_o, 1);
    nxt(); rd_start_i = 1; data_ret_i = 1; #1;
    chk("R5", "discard 2", discard_o, 1);
    chk("R5", "locked", buf_avail_o, 0);
    nxt(); #1;
    chk("R5", "still locked at zero", buf_avail_o, 0);
    chk("R5", "no discard w/o return", discard_o, 0);
    nxt(); buf_empty_i = 1; #1;
    chk("R5", "released", buf_avail_o, 1);
    chk("R12", "start ignored: no disc", disconnect_o, 0);
    chk("R12", "start ignored: no wait", wait_o, 0);
  endtask

  task automatic t_boundary();
    start_burst(0);
    nxt(); boundary_i = 1; #1;
    chk("R6", "no disc before phase", disconnect_o, 0);
    nxt(); boundary_i = 1; phase_done_i = 1; #1;
    chk("R6", "disc on phase", disconnect_o, 1);
    chk("R6", "no wait", wait_o, 0);
    nxt(); #1;
    chk("R6", "drain", buf_avail_o, 0);
    nxt(); #1;
    chk("R6", "released", buf_avail_o, 1);
  endtask

  task automatic t_wrap();
    start_burst(0);
    nxt(); wrap_i = 1; req_issue_i = 1; #1;
    chk("R7", "no disc before phase", disconnect_o, 0);
    nxt(); wrap_i = 1; phase_done_i = 1; #1;
    chk("R7", "disc on phase", disconnect_o, 1);
    nxt(); data_ret_i = 1; #1;
    chk("R7", "late word discarded", discard_o, 1);
    chk("R7", "locked", buf_avail_o, 0);
    nxt(); #1;
    chk("R7", "locked at zero", buf_avail_o, 0);
    nxt(); #1;
    chk("R7", "released", buf_avail_o, 1);
  endtask

  task automatic t_abort();
    start_burst(0);
    nxt(); req_issue_i = 1; #1;
    nxt(); abort_req_i = 1; boundary_i = 1; phase_done_i = 1; #1;
    chk("R8", "abort", abort_o, 1);
    chk("R10", "no disc with abort", disconnect_o, 0);
    chk("R10", "no wait with abort", wait_o, 0);
    nxt(); #1;
    chk("R8", "abort one cycle", abort_o, 0);
    chk("R8", "locked", buf_avail_o, 0);
    nxt(); data_ret_i = 1; #1;
    chk("R8", "discard in flight", discard_o, 1);
    nxt(); #1;
    chk("R8", "locked at zero", buf_avail_o, 0);
    nxt(); #1;
    chk("R8", "released", buf_avail_o, 1);
  endtask

  task automatic t_write();
    start_burst(1);
    nxt(); txn_write_i = 1; abort_req_i = 1; #1;
    chk("R9", "no abort on write", abort_o, 0);
    chk("R9", "no disc", disconnect_o, 0);
    nxt(); txn_write_i = 1; buf_empty_i = 1; #1;
    chk("R9", "normal end", disconnect_o, 1);
    nxt(); #1;
    chk("R9", "released", buf_avail_o, 1);
  endtask

  initial begin
    #50000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_normal();
    t_timeout();
    t_boundary();
    t_wrap();
    t_abort();
    t_write();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule